// File: doc/BRIEF.md
# PHY Management Boot Sequencer

This block runs once after reset to put eight attached Ethernet PHYs into forced half-duplex operation, as a repeater needs. It uses the two-wire MDIO management bus. It reads two configuration straps while reset is held low. One strap skips the whole sequence. The other picks which window of eight consecutive PHY addresses is programmed.

After reset, the block sends one management write frame to each PHY, in ascending address order. Each write goes to the PHY control register. The written value clears the auto-negotiation enable bit and the duplex bit. When the last frame has been sent, the block raises a done flag and then goes quiet.

MDC is derived from the system clock by a counter. The data pin is brought out as a pad output value plus an output enable. The enable is dropped between frames, so the pad goes to high impedance there. There is no host command interface and no read path.

Top module: `mdio_boot_cfg`

## Requirements
- R1: The straps are captured only on clock edges where `rstN` is low. Strap changes after reset release do not change the sequence.
- R2: With `strapBypass` high at reset, `mdioOe` never rises, and `done` is high by the second rising clock edge after reset release.
- R3: With `strapAddrHigh` low at reset, the PHY addresses written are 4 to 11. With it high, they are 8 to 15. In both cases the frames go out in ascending address order.
- R4: Each frame is 64 bits, sent most significant first. It carries 32 ones, start bits 01, opcode 01, the 5-bit PHY address, register address 0 (5 bits), turnaround 10, and then the 16-bit control word. The control word defaults to 0x2000, so bit 12 (auto-negotiation enable) and bit 8 (duplex) are zero.
- R5: MDC is low for exactly `MDC_HALF` system clocks and then high for exactly `MDC_HALF` system clocks, repeating. It starts low after reset.
- R6: `mdioO` and `mdioOe` change only on the system clock edge where MDC falls.
- R7: `mdioOe` is low between frames. Exactly `IDLE_CYCLES` MDC rising edges, 32 by default, pass with the enable low between the end of one frame and the start of the next.
- R8: `done` stays low while frames are pending. It rises on the same edge where the enable drops after the last frame, and it stays high with `mdioOe` low until the next reset.
- R9: Without bypass, exactly `NUM_PHY` frames are sent, 8 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strapBypass | input | 1 | High at reset skips the whole sequence |
| strapAddrHigh | input | 1 | Selects the PHY address window: low gives 4 to 11, high gives 8 to 15 |
| mdc | output | 1 | Management clock |
| mdioO | output | 1 | Value for the management data pad |
| mdioOe | output | 1 | Output enable for the management data pad; low means high impedance |
| done | output | 1 | Sequence finished (or bypassed); sticky until reset |

## Verification
The bench decodes every frame at the MDC rising edges for each strap combination. It compares the whole 64-bit word against one it builds itself. This catches an address window off by one, or a descending order, because a frame then carries the wrong address field.

The bench also checks these corner cases:
- Straps flipped right after reset: a design that samples them continuously would switch window or skip the run.
- Output changes: any change of the pad outputs away from an MDC fall would show a driver that updates on the wrong edge.
- Idle gap: the bench counts the gap exactly, so a counter that stops one short shows up.
- Done flag: it must rise with the last release, not earlier and not never, which exposes a miscounted PHY index.

// File: rtl/mdio_boot_pkg.sv
package mdio_boot_pkg;

  localparam int FRAME_LEN    = 64;
  localparam int PREAMBLE_LEN = 32;

  // Strobes from the sequencer to the shifter, each valid on an MDC fall.
  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic endFrame;
  } mdioStrobe_t;

  // Assemble one clause-22 write frame, most significant bit sent first.
  function automatic logic [FRAME_LEN-1:0] buildWrite(
      input logic [4:0]  phyAddr,
      input logic [4:0]  regAddr,
      input logic [15:0] value);
    logic [FRAME_LEN-1:0] w;
    w = {{PREAMBLE_LEN{1'b1}}, 2'b01, 2'b01, phyAddr, regAddr, 2'b10, value};
    return w;
  endfunction

endpackage

// File: rtl/mdio_shift_path.sv
module mdio_shift_path
  import mdio_boot_pkg::*;
#(
  parameter int          MDC_HALF  = 50,
  parameter logic [4:0]  REG_ADDR  = 5'd0,
  parameter logic [15:0] CTRL_WORD = 16'h2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strobe,
  input  logic [4:0]  phyAddr,
  output logic        fallEv,
  output logic        mdc,
  output logic        mdioO,
  output logic        mdioOe
);

  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(MDC_HALF - 1);

  logic [DIV_W-1:0]     halfCnt;
  logic [FRAME_LEN-1:0] shiftReg;
  logic                 halfEnd;

  assign halfEnd = (halfCnt == HALF_LAST);
  assign fallEv  = halfEnd && mdc;

  // MDC divider: toggles every MDC_HALF system clocks, starting low.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      mdc     <= 1'b0;
    end else if (halfEnd) begin
      halfCnt <= '0;
      mdc     <= ~mdc;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // Data shifter: pad value and enable only move with an MDC fall.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      mdioO    <= 1'b0;
      mdioOe   <= 1'b0;
    end else if (strobe.loadFrame) begin
      shiftReg <= buildWrite(phyAddr, REG_ADDR, CTRL_WORD);
      mdioO    <= buildWrite(phyAddr, REG_ADDR, CTRL_WORD) >> (FRAME_LEN - 1);
      mdioOe   <= 1'b1;
    end else if (strobe.shiftBit) begin
      shiftReg <= shiftReg << 1;
      mdioO    <= shiftReg[FRAME_LEN-2];
    end else if (strobe.endFrame) begin
      mdioO    <= 1'b0;
      mdioOe   <= 1'b0;
    end
  end

  p_pad_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && (!$stable(mdioO) || !$stable(mdioOe))) |-> $fell(mdc));

  p_strobe_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFrame || strobe.shiftBit || strobe.endFrame) |-> fallEv);

  p_mdc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && !halfEnd) |=> $stable(mdc));

endmodule

// File: rtl/mdio_seq_ctl.sv
module mdio_seq_ctl
  import mdio_boot_pkg::*;
#(
  parameter int NUM_PHY     = 8,
  parameter int IDLE_CYCLES = 32,
  parameter int LO_BASE     = 4,
  parameter int HI_BASE     = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bypassLat,
  input  logic        addrHighLat,
  input  logic        fallEv,
  output mdioStrobe_t strobe,
  output logic [4:0]  phyAddr,
  output logic        done
);

  localparam int IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;
  localparam int GAP_W = $clog2(IDLE_CYCLES + 1);
  localparam int BIT_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PHY - 1);

  typedef enum logic [1:0] {ST_START, ST_GAP, ST_FRAME, ST_DONE} seqState_t;

  seqState_t        state;
  logic [GAP_W-1:0] gapCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [IDX_W-1:0] phyIdx;
  logic             lastPhy;
  logic [4:0]       baseAddr;

  assign lastPhy  = (phyIdx == IDX_LAST);
  assign baseAddr = addrHighLat ? 5'(HI_BASE) : 5'(LO_BASE);
  assign phyAddr  = baseAddr + 5'(phyIdx);
  assign done     = (state == ST_DONE);

  always_comb begin
    strobe = '0;
    if (fallEv) begin
      case (state)
        ST_GAP:   strobe.loadFrame = (gapCnt == '0);
        ST_FRAME: begin
          strobe.shiftBit = (bitCnt != '0);
          strobe.endFrame = (bitCnt == '0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_START;
      gapCnt <= '0;
      bitCnt <= '0;
      phyIdx <= '0;
    end else begin
      case (state)
        ST_START: begin
          state  <= bypassLat ? ST_DONE : ST_GAP;
          gapCnt <= '0;
        end
        ST_GAP: if (fallEv) begin
          if (gapCnt == '0) begin
            state  <= ST_FRAME;
            bitCnt <= BIT_W'(FRAME_LEN - 1);
          end else begin
            gapCnt <= gapCnt - 1'b1;
          end
        end
        ST_FRAME: if (fallEv) begin
          if (bitCnt == '0) begin
            if (lastPhy) begin
              state <= ST_DONE;
            end else begin
              phyIdx <= phyIdx + 1'b1;
              gapCnt <= GAP_W'(IDLE_CYCLES - 1);
              state  <= ST_GAP;
            end
          end else begin
            bitCnt <= bitCnt - 1'b1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  p_addr_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |-> (phyAddr >= baseAddr && phyAddr < baseAddr + 5'(NUM_PHY)));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  p_no_frame_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    bypassLat |-> !strobe.loadFrame);

endmodule

// File: rtl/mdio_boot_cfg.sv
module mdio_boot_cfg
  import mdio_boot_pkg::*;
#(
  parameter int          NUM_PHY     = 8,
  parameter int          IDLE_CYCLES = 32,
  parameter int          MDC_HALF    = 50,
  parameter int          LO_BASE     = 4,
  parameter int          HI_BASE     = 8,
  parameter logic [15:0] CTRL_WORD   = 16'h2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic strapBypass,
  input  logic strapAddrHigh,
  output logic mdc,
  output logic mdioO,
  output logic mdioOe,
  output logic done
);

  logic        bypassLat;
  logic        addrHighLat;
  logic        fallEv;
  logic [4:0]  phyAddr;
  mdioStrobe_t strobe;

  // Straps follow the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypassLat   <= strapBypass;
      addrHighLat <= strapAddrHigh;
    end
  end

  mdio_seq_ctl #(
    .NUM_PHY(NUM_PHY), .IDLE_CYCLES(IDLE_CYCLES),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) uCtl (
    .clk(clk), .rstN(rstN), .bypassLat(bypassLat), .addrHighLat(addrHighLat),
    .fallEv(fallEv), .strobe(strobe), .phyAddr(phyAddr), .done(done)
  );

  mdio_shift_path #(
    .MDC_HALF(MDC_HALF), .REG_ADDR(5'd0), .CTRL_WORD(CTRL_WORD)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phyAddr(phyAddr),
    .fallEv(fallEv), .mdc(mdc), .mdioO(mdioO), .mdioOe(mdioOe)
  );

  p_straps_frozen_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(bypassLat) && $stable(addrHighLat)));

  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !mdioOe);

  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    bypassLat |-> !mdioOe);

endmodule

// File: tb/tb_mdio_boot_cfg.sv
`timescale 1ns/1ps
module tb_mdio_boot_cfg;

  localparam int HALF  = 4;
  localparam int IDLE  = 32;
  localparam int NPHY  = 8;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapBypass = 1'b0;
  logic strapAddrHigh = 1'b0;
  logic mdc, mdioO, mdioOe, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  mdio_boot_cfg #(
    .NUM_PHY(NPHY), .IDLE_CYCLES(IDLE), .MDC_HALF(HALF),
    .LO_BASE(4), .HI_BASE(8), .CTRL_WORD(16'h2000)
  ) dut (
    .clk(clk), .rstN(rstN), .strapBypass(strapBypass), .strapAddrHigh(strapAddrHigh),
    .mdc(mdc), .mdioO(mdioO), .mdioOe(mdioOe), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input int addr);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(addr), 5'd0, 2'b10, 16'h2000};
  endfunction

  // One reset and run; byp/hi are the strap values held during reset.
  task automatic runCase(input bit byp, input bit hi, input bit flip);
    logic pM, pO, pOe;
    logic [63:0] acc;
    int bits, frames, idle, lastRise, runLen;
    bit badEdge, badPeriod, badIdle, badDoneEarly;
    rstN = 1'b0;
    strapBypass = byp;
    strapAddrHigh = hi;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0 && done == 1'b0, "R5", "reset state",
          {mdc, mdioOe, done}, 0);
    rstN = 1'b1;
    if (flip) begin
      strapBypass = ~byp;
      strapAddrHigh = ~hi;
    end
    pM = mdc; pO = mdioO; pOe = mdioOe;
    acc = '0; bits = 0; frames = 0; idle = 0; lastRise = -1;
    badEdge = 0; badPeriod = 0; badIdle = 0; badDoneEarly = 0;
    runLen = byp ? 600 : (NPHY * (64 + IDLE) * 2 * HALF + 400);
    for (int c = 0; c < runLen; c++) begin
      @(negedge clk);
      if (c == 1 && byp)
        check(done == 1'b1, "R2", "done after bypass", done, 1);
      if ((mdioO != pO || mdioOe != pOe) && !(pM && !mdc)) badEdge = 1;
      if (!pM && mdc) begin
        if (lastRise >= 0 && (c - lastRise) != 2 * HALF) badPeriod = 1;
        lastRise = c;
        if (mdioOe) begin
          if (bits == 0 && frames > 0 && idle != IDLE) badIdle = 1;
          acc = {acc[62:0], mdioO};
          bits++;
          idle = 0;
        end else begin
          idle++;
        end
      end
      if (mdioOe && done) badDoneEarly = 1;
      if (pOe && !mdioOe) begin
        frames++;
        check(bits == 64, "R4", "frame length", bits, 64);
        check(acc == expFrame((hi ? 8 : 4) + frames - 1), "R3",
              "frame address/content", acc, expFrame((hi ? 8 : 4) + frames - 1));
        check(done == (frames == NPHY), "R8", "done at frame end", done, frames == NPHY);
        bits = 0;
      end
      pM = mdc; pO = mdioO; pOe = mdioOe;
    end
    check(frames == (byp ? 0 : NPHY), "R9", "frame count", frames, byp ? 0 : NPHY);
    check(done == 1'b1, "R8", "done held at end", done, 1);
    check(!badEdge, "R6", "pad change away from MDC fall", badEdge, 0);
    check(!badPeriod, "R5", "MDC period", badPeriod, 0);
    check(!badIdle, "R7", "idle MDC cycles between frames", badIdle, 0);
    check(!badDoneEarly, "R8", "done while driving", badDoneEarly, 0);
    if (flip) check(frames == (byp ? 0 : NPHY), "R1", "straps after reset ignored",
                    frames, byp ? 0 : NPHY);
    if (byp) check(frames == 0, "R2", "no frames in bypass", frames, 0);
  endtask

  initial begin
    runCase(1'b0, 1'b0, 1'b0);   // R3 low window
    runCase(1'b0, 1'b1, 1'b0);   // R3 high window
    runCase(1'b1, 1'b0, 1'b0);   // R2 bypass
    runCase(1'b1, 1'b1, 1'b0);   // R2 bypass, other window
    runCase(1'b0, 1'b1, 1'b1);   // R1 straps flipped after release
    runCase(1'b1, 1'b0, 1'b1);   // R1 bypass kept despite flip
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait (cycles >= LIMIT);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule